// File: doc/BRIEF.md
# Grouped GPIO Direction Controller

This block owns the direction state of a 32-bit general-purpose port whose pins are not all alike. Two pins can change direction on their own. Two 8-bit lanes can change only as a whole lane. Every other pin keeps the direction that its availability gives it. The block holds an input-capable mask and an output-capable mask. It accepts "make these pins inputs" and "make these pins outputs" requests and drives a 4-bit direction configuration register, with one bit per movable group. Each request is answered with the updated mask.

Pin availability comes in on two static inputs. The block samples them on the first clock edge after reset is released. A pin that can be both input and output, and that is not in a movable group, appears in both masks. The direction readback therefore reports it as an output. After each configuration write the block holds off further requests for a settling time given in nanoseconds. The hold is converted into clock cycles from the clock-period parameter, and `busy_o` is high while it counts.

Top module: `gpio_dir_ctrl`

## Requirements
- R1: On the first clock edge after reset is released, the block loads its masks, and `busy_o` is high until that edge. With chg = 32'h01FFFF01 & in_avail_i & out_avail_i, the loaded values are in_mask_o = (in_avail_i & ~chg) | chg and out_mask_o = out_avail_i & ~chg & 32'h7FFFFFFF. `cfg_o` resets to 4'b0000, meaning all groups are inputs.
- R2: Bit 0 and bit 24 each move when their own bit is set in the request and is changeable.
- R3: Lane 8..15 moves only when all eight of its bits are set in the request and all eight are changeable. Lane 16..23 follows the same rule. A partial lane request leaves that lane unchanged.
- R4: Bit positions outside the changeable set never change in either mask after initialisation.
- R5: A request has no effect when every requested bit is already in the target mask, or when no requested bit is changeable. In that case there is no configuration write, the masks do not change and `busy_o` stays low.
- R6: Moving a group to output sets its bits in the output mask and clears them in the input mask. Moving a group to input does the reverse.
- R7: Bit 31 of `out_mask_o` and of `dir_rb_o` is always 0. `dir_rb_o` equals the bits of the groups configured as output, ORed with `out_mask_o`.
- R8: An effective request pulses `cfg_wr_o` for one cycle, in the cycle after the request is accepted. `cfg_o` bit 0 covers pin 0, bit 1 covers lane 8..15, bit 2 covers lane 16..23 and bit 3 covers pin 24. A 1 means output.
- R9: After a configuration write, `busy_o` is high for exactly HOLD = ceil(SETTLE_NS/CLK_NS) cycles. A request presented while `busy_o` is high is dropped and gets no response.
- R10: `rsp_valid_o` pulses for one cycle after every accepted request. `rsp_mask_o` then carries `out_mask_o` for an output request (`req_dir_i`=1) and `in_mask_o` for an input request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_avail_i | input | 32 | Static input-capable pins |
| out_avail_i | input | 32 | Static output-capable pins |
| req_valid_i | input | 1 | Request strobe |
| req_dir_i | input | 1 | Target direction: 1 output, 0 input |
| req_mask_i | input | 32 | Pins to move |
| busy_o | output | 1 | Initialising or settling; requests are dropped |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_mask_o | output | 32 | Updated mask for the requested direction |
| in_mask_o | output | 32 | Current input mask |
| out_mask_o | output | 32 | Current output mask, low 31 bits |
| dir_rb_o | output | 32 | Direction readback, low 31 bits |
| cfg_o | output | 4 | Direction configuration register |
| cfg_wr_o | output | 1 | Configuration write strobe |

## Verification
The hardest states to reach are a lane that is changeable in only some of its bits, and a request that arrives during the settling hold. A random full-lane request almost never occurs. The stimulus therefore ORs whole lanes into the random masks on purpose. It also reruns everything under a second availability pair whose lane 8..15 is only partly changeable. Dropped requests are placed one cycle after a configuration write, while the hold counter is still running.

// File: rtl/gdir_pkg.sv
package gdir_pkg;
  localparam int unsigned PORT_W   = 32;
  localparam int unsigned NGRP     = 4;
  localparam logic [PORT_W-1:0] CHG_MASK = 32'h01FF_FF01;
  localparam logic [PORT_W-1:0] RB_MASK  = 32'h7FFF_FFFF;

  // group order sets the cfg register bit order
  function automatic logic [PORT_W-1:0] grp_mask(input int unsigned g);
    case (g)
      0:       return 32'h0000_0001;
      1:       return 32'h0000_FF00;
      2:       return 32'h00FF_0000;
      default: return 32'h0100_0000;
    endcase
  endfunction
endpackage

// File: rtl/gdir_group_eval.sv
module gdir_group_eval
  import gdir_pkg::*;
(
  input  logic [PORT_W-1:0] req_mask_i,
  input  logic [PORT_W-1:0] chg_i,
  output logic [NGRP-1:0]   fire_o
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [PORT_W-1:0] M = grp_mask(g);
    // a group moves only when every one of its bits is requested and changeable
    assign fire_o[g] = ((req_mask_i & chg_i & M) == M);
  end
endmodule

// File: rtl/gdir_pacer.sv
module gdir_pacer #(
  parameter int unsigned HOLD = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= HOLD_C;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/gpio_dir_ctrl.sv
module gpio_dir_ctrl
  import gdir_pkg::*;
#(
  parameter int unsigned CLK_NS    = 5,
  parameter int unsigned SETTLE_NS = 120
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] in_avail_i,
  input  logic [31:0] out_avail_i,
  input  logic        req_valid_i,
  input  logic        req_dir_i,
  input  logic [31:0] req_mask_i,
  output logic        busy_o,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_mask_o,
  output logic [31:0] in_mask_o,
  output logic [31:0] out_mask_o,
  output logic [31:0] dir_rb_o,
  output logic [3:0]  cfg_o,
  output logic        cfg_wr_o
);
  localparam int unsigned HOLD = (SETTLE_NS + CLK_NS - 1) / CLK_NS;

  logic              init_q;
  logic [PORT_W-1:0] chg_q, in_q, out_q;
  logic [NGRP-1:0]   cfg_q;
  logic              rsp_q, rsp_dir_q, wr_q;
  logic              pace_busy, accept, effective;
  logic [NGRP-1:0]   fire;
  logic [PORT_W-1:0] tgt, in_d, out_d, chg_init, shadow;
  logic [NGRP-1:0]   cfg_d;

  gdir_group_eval u_eval (
    .req_mask_i (req_mask_i),
    .chg_i      (chg_q),
    .fire_o     (fire)
  );

  gdir_pacer #(.HOLD(HOLD)) u_pacer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (effective),
    .busy_o  (pace_busy)
  );

  assign busy_o    = !init_q || pace_busy;
  assign accept    = req_valid_i && !busy_o;
  assign tgt       = req_dir_i ? out_q : in_q;
  assign effective = accept && ((req_mask_i & tgt) != req_mask_i)
                            && ((req_mask_i & chg_q) != '0);
  assign chg_init  = CHG_MASK & in_avail_i & out_avail_i;

  always_comb begin
    in_d  = in_q;
    out_d = out_q;
    cfg_d = cfg_q;
    for (int g = 0; g < NGRP; g++) begin
      if (fire[g]) begin
        cfg_d[g] = req_dir_i;
        if (req_dir_i) begin
          out_d = out_d | grp_mask(g);
          in_d  = in_d & ~grp_mask(g);
        end else begin
          in_d  = in_d | grp_mask(g);
          out_d = out_d & ~grp_mask(g);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q    <= 1'b0;
      chg_q     <= '0;
      in_q      <= '0;
      out_q     <= '0;
      cfg_q     <= '0;
      rsp_q     <= 1'b0;
      rsp_dir_q <= 1'b0;
      wr_q      <= 1'b0;
    end else begin
      rsp_q <= accept;
      wr_q  <= effective;
      if (accept) rsp_dir_q <= req_dir_i;
      if (!init_q) begin
        // all groups reset to input, so changeable bits join the input mask
        init_q <= 1'b1;
        chg_q  <= chg_init;
        in_q   <= (in_avail_i & ~chg_init) | chg_init;
        out_q  <= out_avail_i & ~chg_init;
      end else if (effective) begin
        in_q  <= in_d;
        out_q <= out_d;
        cfg_q <= cfg_d;
      end
    end
  end

  always_comb begin
    shadow = '0;
    for (int g = 0; g < NGRP; g++)
      if (cfg_q[g]) shadow = shadow | grp_mask(g);
  end

  assign in_mask_o   = in_q;
  assign out_mask_o  = out_q & RB_MASK;
  assign dir_rb_o    = (shadow | out_q) & RB_MASK;
  assign cfg_o       = cfg_q;
  assign cfg_wr_o    = wr_q;
  assign rsp_valid_o = rsp_q;
  assign rsp_mask_o  = rsp_dir_q ? out_mask_o : in_mask_o;
endmodule

// File: rtl/gpio_dir_ctrl_chk.sv
module gpio_dir_ctrl_chk
  import gdir_pkg::*;
#(
  parameter int unsigned HOLD = 24
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        init_q,
  input logic        busy_o,
  input logic        rsp_valid_o,
  input logic [31:0] in_mask_o,
  input logic [31:0] out_mask_o,
  input logic [31:0] dir_rb_o,
  input logic        cfg_wr_o
);
  localparam int unsigned GW = $clog2(HOLD + 1);
  localparam logic [GW-1:0] HOLD_C = GW'(HOLD);
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            gap_q <= HOLD_C;
    else if (cfg_wr_o)      gap_q <= GW'(1);
    else if (gap_q < HOLD_C) gap_q <= gap_q + 1'b1;
  end

  // R9
  pace_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_o |-> gap_q >= HOLD_C);

  // R9
  busy_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_o |-> busy_o);

  // R8
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_o |=> !cfg_wr_o);

  // R10
  wr_has_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_o |-> rsp_valid_o);

  // R4
  fixed_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q |=> (((in_mask_o ^ $past(in_mask_o)) | (out_mask_o ^ $past(out_mask_o)))
                & ~CHG_MASK) == '0);

  // R5
  quiet_masks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(init_q) && !cfg_wr_o) |-> ($stable(in_mask_o) && $stable(out_mask_o)));

  // R7
  rb_top_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_mask_o[31] && !dir_rb_o[31] && ((out_mask_o & ~dir_rb_o) == '0));
endmodule

bind gpio_dir_ctrl gpio_dir_ctrl_chk #(.HOLD(HOLD)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .init_q      (init_q),
  .busy_o      (busy_o),
  .rsp_valid_o (rsp_valid_o),
  .in_mask_o   (in_mask_o),
  .out_mask_o  (out_mask_o),
  .dir_rb_o    (dir_rb_o),
  .cfg_wr_o    (cfg_wr_o)
);

// File: tb/gpio_dir_ctrl_tb.sv
module gpio_dir_ctrl_tb;
  localparam int unsigned CLK_NS = 5;
  localparam int unsigned HOLD   = (120 + CLK_NS - 1) / CLK_NS;
  localparam logic [31:0] CHG    = 32'h01FF_FF01;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] in_av = '0, out_av = '0;
  logic        req_valid = 1'b0, req_dir = 1'b0;
  logic [31:0] req_mask = '0;
  logic        busy, rsp_valid, cfg_wr;
  logic [31:0] rsp_mask, in_mask, out_mask, dir_rb;
  logic [3:0]  cfg;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_chg, m_in, m_out;
  logic [3:0]  m_cfg;

  always #2.5 clk = ~clk;

  gpio_dir_ctrl #(.CLK_NS(CLK_NS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_avail_i(in_av), .out_avail_i(out_av),
    .req_valid_i(req_valid), .req_dir_i(req_dir), .req_mask_i(req_mask),
    .busy_o(busy), .rsp_valid_o(rsp_valid), .rsp_mask_o(rsp_mask),
    .in_mask_o(in_mask), .out_mask_o(out_mask), .dir_rb_o(dir_rb),
    .cfg_o(cfg), .cfg_wr_o(cfg_wr)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] gm(input int g);
    case (g)
      0: return 32'h1;
      1: return 32'h0000_FF00;
      2: return 32'h00FF_0000;
      default: return 32'h0100_0000;
    endcase
  endfunction

  function automatic logic [31:0] exp_rb();
    logic [31:0] s = '0;
    for (int g = 0; g < 4; g++) if (m_cfg[g]) s |= gm(g);
    return (s | m_out) & 32'h7FFF_FFFF;
  endfunction

  task automatic check_state(input string tag);
    chk(in_mask == m_in, {tag, " in_mask"}, in_mask, m_in);
    chk(out_mask == (m_out & 32'h7FFF_FFFF), {tag, " out_mask"}, out_mask,
        m_out & 32'h7FFF_FFFF);
    chk(dir_rb == exp_rb(), {tag, " R7 dir_rb"}, dir_rb, exp_rb());
    chk(cfg == m_cfg, {tag, " R8 cfg"}, {28'd0, cfg}, {28'd0, m_cfg});
  endtask

  task automatic do_reset(input logic [31:0] ia, input logic [31:0] oa);
    rst_n = 1'b0;
    in_av = ia; out_av = oa;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(busy == 1'b1, "R1 busy before init", {31'd0, busy}, 32'd1);
    chk(cfg == 4'b0, "R1 cfg reset", {28'd0, cfg}, 32'd0);
    @(negedge clk);
    m_chg = CHG & ia & oa;
    m_in  = (ia & ~m_chg) | m_chg;
    m_out = oa & ~m_chg;
    m_cfg = '0;
    chk(busy == 1'b0, "R1 busy after init", {31'd0, busy}, 32'd0);
    check_state("R1 init");
  endtask

  // drive one request when idle, check response, state and hold length
  task automatic do_req(input logic dir, input logic [31:0] mask, input logic poke_busy);
    logic [31:0] tgt;
    logic eff;
    int bc;
    while (busy) @(negedge clk);
    tgt = dir ? m_out : m_in;
    eff = ((mask & tgt) != mask) && ((mask & m_chg) != 0);
    if (eff)
      for (int g = 0; g < 4; g++)
        if ((mask & m_chg & gm(g)) == gm(g)) begin
          m_cfg[g] = dir;
          if (dir) begin m_out |= gm(g); m_in &= ~gm(g); end
          else begin m_in |= gm(g); m_out &= ~gm(g); end
        end
    req_valid = 1'b1; req_dir = dir; req_mask = mask;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R10 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk(rsp_mask == (dir ? m_out & 32'h7FFF_FFFF : m_in), "R10 rsp_mask", rsp_mask,
        dir ? m_out & 32'h7FFF_FFFF : m_in);
    chk(cfg_wr == eff, "R8 R5 cfg_wr", {31'd0, cfg_wr}, {31'd0, eff});
    chk(busy == eff, "R5 R9 busy", {31'd0, busy}, {31'd0, eff});
    check_state("R2 R3 R4 R6 req");
    if (eff) begin
      bc = 0;
      if (poke_busy) begin
        req_valid = 1'b1; req_dir = ~dir; req_mask = 32'hFFFF_FFFF;
        @(negedge clk);
        req_valid = 1'b0;
        bc++;
        chk(rsp_valid == 1'b0, "R9 dropped rsp", {31'd0, rsp_valid}, 32'd0);
        chk(cfg_wr == 1'b0, "R9 dropped wr", {31'd0, cfg_wr}, 32'd0);
        check_state("R9 dropped");
      end
      while (busy && bc < 1000) begin @(negedge clk); bc++; end
      chk(bc == HOLD, "R9 hold length", bc, HOLD);
    end else begin
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R10 rsp one cycle", {31'd0, rsp_valid}, 32'd0);
    end
  endtask

  function automatic logic [31:0] rnd_mask();
    logic [31:0] m = $urandom;
    logic [3:0]  sel = 4'($urandom);
    if (sel[0]) m = m & $urandom & $urandom;
    if (sel[1]) m |= 32'h0000_FF00;
    if (sel[2]) m |= 32'h00FF_0000;
    if (sel[3]) m |= 32'h0100_0001;
    return m;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    // availability A: everything capable both ways
    do_reset(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    do_req(1'b1, 32'h0000_0001, 1'b0);   // R2 bit 0 alone
    do_req(1'b1, 32'h0100_0000, 1'b1);   // R2 bit 24 alone, R9 drop
    do_req(1'b1, 32'h0000_7F00, 1'b0);   // R3 partial lane, bits still changeable
    do_req(1'b1, 32'h00FF_0000, 1'b0);   // R3 full lane, R6
    do_req(1'b1, 32'h00FF_0000, 1'b0);   // R5 already output
    do_req(1'b0, 32'h8000_0000, 1'b0);   // R5 nothing changeable, R4
    do_req(1'b0, 32'h00FF_FF01, 1'b1);   // R6 back to input
    for (int i = 0; i < 150; i++) do_req(1'($urandom), rnd_mask(), 1'($urandom));
    // availability B: lane 8..15 only partly changeable
    do_reset(32'h0FF0_FFF1, 32'hF1FF_F0FF);
    do_req(1'b1, 32'h0000_FF00, 1'b0);   // R3 lane cannot move
    do_req(1'b1, 32'h01FF_FF01, 1'b1);
    for (int i = 0; i < 150; i++) do_req(1'($urandom), rnd_mask(), 1'($urandom));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule